// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor with a single accumulator. Every instruction passes through a fetch phase, a decode phase and an execute phase, and each phase is spread over several clock cycles. The core has a program counter, a memory address register (MAR), a memory data register (MDR), an instruction register and an accumulator with a zero flag. Each register transfer takes one cycle of the control state machine.

The core is connected to one shared synchronous memory. The address comes only from MAR and flows one way, from the core to memory. Read data and write data use separate buses. The MDR is the only register that exchanges words with memory. Instruction fetches and operand accesses both use MAR and MDR, and separate read and write strobes qualify each memory access.

A program is placed in memory and the core is released from reset. It then runs until it reaches a HALT instruction. The results can be seen in memory, on the accumulator output and on the halted output.

Top module: `acc_cpu`

## Requirements
- R1: An active-low asynchronous reset clears PC, MAR, MDR, the instruction register, the accumulator and the zero flag. While reset is held, both strobes are low, halted is low and the address output is 0. After release the core starts fetching from address 0.
- R2: The fetch sequence is: MAR takes PC; the read strobe is driven with MAR on the address output; one wait cycle follows while memory answers with one cycle of latency; MDR latches the returned word; the instruction register takes MDR; PC increments. The first read strobe comes one cycle after reset is released, and its address is 0.
- R3: An instruction word has the opcode in bits 15:12 and a direct address in bits 11:0. The opcodes are 0 NOP, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 AND, 6 OR, 7 JMP, 8 JZ and F HALT.
- R4: LOAD copies the word at the operand address into the accumulator. ADD, SUB, AND and OR combine the accumulator with that word and write the 16-bit result back to the accumulator. ADD and SUB wrap modulo 2^16.
- R5: LOAD, ADD, SUB, AND and OR set the zero flag when the new accumulator value is 0 and clear it otherwise. STORE, JMP, JZ and NOP leave the flag unchanged.
- R6: STORE moves the accumulator into MDR and then drives a single write strobe, with MDR on the write data bus and the operand address on the address output.
- R7: JMP always loads PC with its address field. JZ loads PC only when the zero flag is set; otherwise the next sequential instruction runs. No other register is changed by a jump.
- R8: HALT raises the halted output. The output stays high, and no read or write strobe occurs, until the next reset.
- R9: Opcode 0 and the unused opcodes 9 through E execute as no-ops.
- R10: An instruction takes a fixed number of cycles: 6 for a no-op, 7 for JMP or JZ, 9 for STORE and 10 for LOAD or an ALU operation.
- R11: The read and write strobes are never asserted in the same cycle, and every read strobe is followed by a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | ADDR_W | Memory address, always the MAR contents |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after a read strobe |
| mem_wdata_o | output | DATA_W | Write data, always the MDR contents |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| acc_o | output | DATA_W | Accumulator value |
| zero_o | output | 1 | Zero flag |
| halted_o | output | 1 | Core is halted |

## Verification
The assertions check several rules on every cycle. The strobes are mutually exclusive, and a quiet cycle follows each read. MDR is loaded only in the cycle after a read strobe. Write data equals the accumulator whenever the write strobe is high. The zero flag follows the accumulator when the accumulator is written and holds otherwise. PC either steps by one or changes because a jump was taken. Halting is permanent and produces no strobes. Some behaviour needs whole programs and is covered only by the bench's scenarios: ALU results, fetch addresses and their order, cycle counts per instruction class, taken and untaken branches, a skipped store, and no-op handling of unused opcodes.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_AND   = 4'h5,
    OP_OR    = 4'h6,
    OP_JMP   = 4'h7,
    OP_JZ    = 4'h8,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_READ,
    ST_F_WAIT,
    ST_F_IR,
    ST_F_INC,
    ST_DECODE,
    ST_O_ADDR,
    ST_O_READ,
    ST_O_WAIT,
    ST_X_ALU,
    ST_S_DATA,
    ST_S_WRITE,
    ST_X_JUMP,
    ST_HALTED
  } state_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mdr_from_mem;
    logic    mdr_from_acc;
    logic    ir_load;
    logic    pc_inc;
    logic    pc_load;
    logic    acc_we;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e            op_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic [DATA_W-1:0]  opnd_i,
  output logic [DATA_W-1:0]  y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = acc_i + opnd_i;
      ALU_SUB: y_o = acc_i - opnd_i;
      ALU_AND: y_o = acc_i & opnd_i;
      ALU_OR:  y_o = acc_i | opnd_i;
      default: y_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             zero_i,
  output ctrl_t            ctrl_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             halted_o
);

  state_e  state_q, state_d;
  opcode_e op_q;

  function automatic logic needs_opnd(opcode_e op);
    return op inside {OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_AND, OP_OR};
  endfunction

  function automatic alu_op_e alu_sel(opcode_e op);
    unique case (op)
      OP_ADD:  return ALU_ADD;
      OP_SUB:  return ALU_SUB;
      OP_AND:  return ALU_AND;
      OP_OR:   return ALU_OR;
      default: return ALU_PASS;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_F_ADDR;
      op_q    <= OP_NOP;
    end else begin
      state_q <= state_d;
      // decode latches the operation used by the execute states
      if (state_q == ST_DECODE) op_q <= opcode_e'(opcode_i);
    end
  end

  always_comb begin
    state_d  = state_q;
    ctrl_o   = '0;
    ctrl_o.alu_op = alu_sel(op_q);
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    unique case (state_q)
      ST_F_ADDR: begin
        ctrl_o.mar_from_pc = 1'b1;
        state_d = ST_F_READ;
      end
      ST_F_READ: begin
        mem_rd_o = 1'b1;
        state_d  = ST_F_WAIT;
      end
      ST_F_WAIT: begin
        ctrl_o.mdr_from_mem = 1'b1;
        state_d = ST_F_IR;
      end
      ST_F_IR: begin
        ctrl_o.ir_load = 1'b1;
        state_d = ST_F_INC;
      end
      ST_F_INC: begin
        ctrl_o.pc_inc = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        if (needs_opnd(opcode_e'(opcode_i)))          state_d = ST_O_ADDR;
        else if (opcode_e'(opcode_i) inside {OP_JMP, OP_JZ}) state_d = ST_X_JUMP;
        else if (opcode_e'(opcode_i) == OP_HALT)      state_d = ST_HALTED;
        else                                          state_d = ST_F_ADDR;
      end
      ST_O_ADDR: begin
        ctrl_o.mar_from_ir = 1'b1;
        state_d = (op_q == OP_STORE) ? ST_S_DATA : ST_O_READ;
      end
      ST_O_READ: begin
        mem_rd_o = 1'b1;
        state_d  = ST_O_WAIT;
      end
      ST_O_WAIT: begin
        ctrl_o.mdr_from_mem = 1'b1;
        state_d = ST_X_ALU;
      end
      ST_X_ALU: begin
        ctrl_o.acc_we = 1'b1;
        state_d = ST_F_ADDR;
      end
      ST_S_DATA: begin
        ctrl_o.mdr_from_acc = 1'b1;
        state_d = ST_S_WRITE;
      end
      ST_S_WRITE: begin
        mem_wr_o = 1'b1;
        state_d  = ST_F_ADDR;
      end
      ST_X_JUMP: begin
        ctrl_o.pc_load = (op_q == OP_JMP) || zero_i;
        state_d = ST_F_ADDR;
      end
      ST_HALTED: state_d = ST_HALTED;
      default:   state_d = ST_F_ADDR;
    endcase
  end

  assign halted_o = (state_q == ST_HALTED);

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11

  AST_READ_THEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o && !mem_wr_o); // R11

  AST_HALT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_rd_o && !mem_wr_o); // R8

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R8

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_y_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  logic              zero_q;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      acc_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      if (ctrl_i.mar_from_pc)       mar_q <= pc_q;
      else if (ctrl_i.mar_from_ir)  mar_q <= ir_addr;

      if (ctrl_i.mdr_from_mem)      mdr_q <= mem_rdata_i;
      else if (ctrl_i.mdr_from_acc) mdr_q <= acc_q;

      if (ctrl_i.ir_load)           ir_q <= mdr_q;

      if (ctrl_i.pc_load)           pc_q <= ir_addr;
      else if (ctrl_i.pc_inc)       pc_q <= pc_q + ADDR_W'(1);

      if (ctrl_i.acc_we) begin
        acc_q  <= alu_y_i;
        zero_q <= (alu_y_i == '0);
      end
    end
  end

  assign mar_o    = mar_q;
  assign mdr_o    = mdr_q;
  assign opcode_o = ir_q[DATA_W-1 -: OPC_W];
  assign acc_o    = acc_q;
  assign zero_o   = zero_q;

  AST_MDR_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.mdr_from_mem |-> $past(mem_rd_i)); // R2

  AST_WDATA_IS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> mdr_q == acc_q); // R6

  AST_ZERO_TRACKS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_i.acc_we) |-> zero_q == (acc_q == '0)); // R5

  AST_ZERO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_i.acc_we) |-> $stable(zero_q)); // R5

  AST_PC_STEP_OR_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + ADDR_W'(1)) || $past(ctrl_i.pc_load)); // R7

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              halted_o
);

  ctrl_t             ctrl;
  logic [OPC_W-1:0]  opcode;
  logic [DATA_W-1:0] mdr, acc, alu_y;
  logic              zero;

  acc_cpu_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .zero_i   (zero),
    .ctrl_o   (ctrl),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .halted_o (halted_o)
  );

  acc_cpu_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rd_i    (mem_rd_o),
    .mem_wr_i    (mem_wr_o),
    .mem_rdata_i (mem_rdata_i),
    .alu_y_i     (alu_y),
    .mar_o       (mem_addr_o),
    .mdr_o       (mdr),
    .opcode_o    (opcode),
    .acc_o       (acc),
    .zero_o      (zero)
  );

  acc_cpu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op_i   (ctrl.alu_op),
    .acc_i  (acc),
    .opnd_i (mdr),
    .y_o    (alu_y)
  );

  assign mem_wdata_o = mdr;
  assign acc_o       = acc;
  assign zero_o      = zero;

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int MW = 512;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata_i;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_rd_o, mem_wr_o, zero_o, halted_o;
  logic [DW-1:0] acc_o;

  always #4 clk_i = ~clk_i;

  acc_cpu #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .mem_wdata_o(mem_wdata_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .acc_o(acc_o), .zero_o(zero_o), .halted_o(halted_o)
  );

  // behavioural memory, one-cycle read latency; bench loads via tb_* while core is in reset
  logic [DW-1:0] mem [MW];
  logic          tb_clr = 1'b0, tb_we = 1'b0;
  logic [8:0]    tb_a = '0;
  logic [DW-1:0] tb_d = '0;
  int            rd_cnt, wr_cnt, both_cnt;

  always @(posedge clk_i) begin
    if (tb_clr) begin
      for (int i = 0; i < MW; i++) mem[i] <= '0;
      rd_cnt <= 0; wr_cnt <= 0; both_cnt <= 0;
      mem_rdata_i <= '0;
    end else begin
      if (tb_we) mem[tb_a] <= tb_d;
      else if (mem_wr_o) mem[mem_addr_o[8:0]] <= mem_wdata_o;
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[8:0]];
      if (rst_ni) begin
        if (mem_rd_o) rd_cnt <= rd_cnt + 1;
        if (mem_wr_o) wr_cnt <= wr_cnt + 1;
        if (mem_rd_o && mem_wr_o) both_cnt <= both_cnt + 1;
      end
    end
  end

  typedef struct packed {
    logic [3:0]    op;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] res;
    logic          z;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'h3, 16'h1234, 16'h0001, 16'h1235, 1'b0},
    '{4'h3, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
    '{4'h4, 16'h0005, 16'h0005, 16'h0000, 1'b1},
    '{4'h4, 16'h0000, 16'h0001, 16'hFFFF, 1'b0},
    '{4'h5, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0},
    '{4'h5, 16'hAAAA, 16'h5555, 16'h0000, 1'b1},
    '{4'h6, 16'hA000, 16'h0005, 16'hA005, 1'b0},
    '{4'h1, 16'h1111, 16'h0000, 16'h0000, 1'b1}
  };

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic poke(input logic [8:0] a, input logic [DW-1:0] d);
    tb_a = a; tb_d = d; tb_we = 1'b1;
    @(negedge clk_i);
    tb_we = 1'b0;
  endtask

  task automatic prep();
    rst_ni = 1'b0;
    @(negedge clk_i);
    tb_clr = 1'b1;
    @(negedge clk_i);
    tb_clr = 1'b0;
  endtask

  task automatic run(output int cyc);
    rst_ni = 1'b1;
    cyc = 0;
    while (cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
      if (halted_o) break;
    end
    chk(halted_o, "R8 watchdog: program halts", 32'(halted_o), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;

    // R1 reset state and R2 first fetch timing (memory all zero = NOPs)
    prep();
    chk(!mem_rd_o && !mem_wr_o, "R1 no strobes in reset", {mem_rd_o, mem_wr_o}, 0);
    chk(mem_addr_o == 0, "R1 address zero in reset", mem_addr_o, 0);
    chk(acc_o == 0 && !zero_o && !halted_o, "R1 acc/zero/halted clear", {acc_o, zero_o, halted_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_rd_o && mem_addr_o == 0, "R2 first read at address 0", {mem_rd_o, mem_addr_o}, {1'b1, 12'h000});
    @(negedge clk_i);
    chk(!mem_rd_o && !mem_wr_o, "R2 wait cycle after read", {mem_rd_o, mem_wr_o}, 0);
    repeat (5) @(negedge clk_i);
    chk(mem_rd_o && mem_addr_o == 1, "R9 R10 NOP 6 cycles, next fetch at PC+1", {mem_rd_o, mem_addr_o}, {1'b1, 12'h001});

    // R3 R4 R5 R6 R10: vector table, program LOAD a; OP b; STORE r; HALT
    for (int v = 0; v < NV; v++) begin
      prep();
      poke(9'h000, ins(4'h1, 12'h100));
      poke(9'h001, ins(VECS[v].op, 12'h101));
      poke(9'h002, ins(4'h2, 12'h102));
      poke(9'h003, ins(4'hF, 12'h000));
      poke(9'h100, VECS[v].a);
      poke(9'h101, VECS[v].b);
      run(cyc);
      chk(acc_o == VECS[v].res, "R4 accumulator result", acc_o, VECS[v].res);
      chk(zero_o == VECS[v].z, "R5 zero flag", zero_o, VECS[v].z);
      chk(mem[9'h102] == VECS[v].res && wr_cnt == 1, "R6 stored word", mem[9'h102], VECS[v].res);
      chk(cyc == 35, "R10 R3 program cycle count", cyc, 35);
    end
    chk(both_cnt == 0, "R11 strobes exclusive", both_cnt, 0);

    // R10 LOAD then HALT: 10 + 6 cycles
    prep();
    poke(9'h000, ins(4'h1, 12'h100));
    poke(9'h001, ins(4'hF, 12'h000));
    poke(9'h100, 16'h00AB);
    run(cyc);
    chk(cyc == 16, "R10 LOAD+HALT cycles", cyc, 16);

    // R7 JMP skips a STORE: 7 + 6 cycles, no writes
    prep();
    poke(9'h000, ins(4'h7, 12'h005));
    poke(9'h001, ins(4'h2, 12'h100));
    poke(9'h005, ins(4'hF, 12'h000));
    run(cyc);
    chk(cyc == 13 && wr_cnt == 0, "R7 JMP taken, store skipped", {cyc, wr_cnt}, {32'd13, 32'd0});

    // R7 JZ taken then JZ not taken
    prep();
    poke(9'h000, ins(4'h1, 12'h100));
    poke(9'h001, ins(4'h8, 12'h004));
    poke(9'h002, ins(4'h1, 12'h101));
    poke(9'h003, ins(4'hF, 12'h000));
    poke(9'h004, ins(4'h1, 12'h102));
    poke(9'h005, ins(4'h8, 12'h007));
    poke(9'h006, ins(4'h2, 12'h103));
    poke(9'h007, ins(4'hF, 12'h000));
    poke(9'h101, 16'h1234);
    poke(9'h102, 16'h7777);
    run(cyc);
    chk(acc_o == 16'h7777, "R7 JZ taken path", acc_o, 16'h7777);
    chk(mem[9'h103] == 16'h7777 && cyc == 49, "R7 JZ not taken falls through", mem[9'h103], 16'h7777);

    // R5 zero flag kept across STORE, NOP and JMP
    prep();
    poke(9'h000, ins(4'h1, 12'h100));
    poke(9'h001, ins(4'h2, 12'h101));
    poke(9'h002, ins(4'h0, 12'h000));
    poke(9'h003, ins(4'h7, 12'h004));
    poke(9'h004, ins(4'hF, 12'h000));
    run(cyc);
    chk(zero_o == 1'b1, "R5 flag unchanged by STORE/NOP/JMP", zero_o, 1);

    // R9 unused opcodes act as no-ops
    prep();
    poke(9'h000, ins(4'h1, 12'h100));
    poke(9'h001, ins(4'h9, 12'hABC));
    poke(9'h002, ins(4'hE, 12'h100));
    poke(9'h003, ins(4'h2, 12'h101));
    poke(9'h004, ins(4'hF, 12'h000));
    poke(9'h100, 16'h0005);
    run(cyc);
    chk(mem[9'h101] == 16'h0005 && acc_o == 16'h0005, "R9 unused opcode no effect", mem[9'h101], 16'h0005);
    chk(cyc == 37 && !zero_o, "R9 unused opcode cycles", cyc, 37);

    // R8 halted is sticky and silent
    begin
      int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      repeat (40) @(negedge clk_i);
      chk(halted_o && rd_cnt == r0 && wr_cnt == w0, "R8 no access after HALT", rd_cnt + wr_cnt, r0 + w0);
    end

    // R1 asynchronous reset mid-program
    prep();
    poke(9'h000, ins(4'h1, 12'h100));
    poke(9'h001, ins(4'h3, 12'h100));
    poke(9'h100, 16'h0042);
    rst_ni = 1'b1;
    repeat (15) @(negedge clk_i);
    chk(acc_o == 16'h0042, "R4 LOAD before reset", acc_o, 16'h0042);
    #2 rst_ni = 1'b0;
    #1;
    chk(acc_o == 0 && !mem_rd_o && !mem_wr_o && mem_addr_o == 0, "R1 async reset clears", acc_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule